// File: doc/BRIEF.md
# Externally Clocked Serial Read Port for a Converter Output Word

This block is the slave end of a serial read link in which the host supplies the bit clock. The host pulls an active-low read strobe and toggles a serial clock, and the block shifts out, MSB first, one of three sources. These are the latest conversion word, a 24-bit control word, or one of several 24-bit calibration words. An address input and a calibration-enable input choose the source. The serial clock is brought into the system clock domain through a three-stage sampler, and only its falling edges advance the shifter.

The block also owns an active-low data-ready flag. The flag falls when a new conversion word is accepted and rises once every bit of that word has been read. A read of the conversion word can pause when the strobe is released and resume later at the same bit. A word that arrives while such a read is in progress is lost. Control and calibration reads neither need nor touch the flag.

Top module: `adc_rdport`

## Requirements
- R1: With `addr_hi` low, a read returns `ctrl_word` as 24 bits, MSB first.
- R2: With `addr_hi` high and `cal_en` high, a read returns the calibration word chosen by `cal_idx`, which selects bits `[cal_idx*24 +: 24]` of `cal_words`. The read is 24 bits, MSB first.
- R3: With `addr_hi` high and `cal_en` low, a read returns the conversion word. When `len24` is 1 this is all 24 bits. When `len24` is 0 it is only bits [15:0], and the frame is 16 bits long.
- R4: A `word_valid` pulse outside a conversion-word read stores `word_data` and drives `drdy_n` low. Later words that are never read overwrite it, and a read returns the most recent one.
- R5: For a frame of N bits, the LSB is on `sdata_out` after the (N-1)th synchronised SCLK falling edge. On the Nth falling edge, `drdy_n` goes high (conversion reads only) and `sdata_oe` goes low.
- R6: A `word_valid` pulse from the start of a conversion-word read until its last bit is discarded. The word being read is unchanged, and `drdy_n` rises at the end as usual.
- R7: A conversion-word read requested while `drdy_n` is high does not start: `sdata_oe` stays 0 and SCLK edges have no effect.
- R8: Raising `rd_n` mid-frame drives `sdata_oe` to 0 and keeps the bit position. SCLK edges while released are ignored, `drdy_n` stays low, and lowering `rd_n` again continues with the next bit.
- R9: Control and calibration reads are not gated by `drdy_n` and never raise it. A word arriving during such a read is accepted and drives `drdy_n` low.
- R10: A frame starts only on a high-to-low change of `rd_n` sampled on `clk`, and the MSB is driven one `clk` cycle later. Keeping `rd_n` low after a frame ends starts nothing. An SCLK falling edge updates `sdata_out` three `clk` edges after it is first sampled.
- R11: After reset, `drdy_n` is 1, `sdata_oe` is 0 and `sdata_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| rd_n | input | 1 | Active-low read strobe |
| addr_hi | input | 1 | 1: conversion or calibration data, 0: control word |
| cal_en | input | 1 | With addr_hi high, 1 selects calibration data |
| cal_idx | input | CIDX_W | Calibration word index |
| len24 | input | 1 | Conversion word length, 1: 24 bits, 0: 16 bits |
| word_valid | input | 1 | New conversion word strobe |
| word_data | input | 24 | New conversion word |
| ctrl_word | input | 24 | Control register contents |
| cal_words | input | N_CAL*24 | Calibration register contents, packed |
| sdata_out | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data output enable |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
If the bit counter is wrong, the frame ends early or late, so `drdy_n` rises and `sdata_oe` drops on the wrong falling edge. This shows up within one SCLK period of the true last bit. A wrong drop or hold decision shows up in two ways: a mid-read word corrupts the remaining bits of the frame, or `drdy_n` is low after the frame where it should be high. A source-select fault shows from the first bit after the strobe falls.

// File: rtl/adc_rdport_pkg.sv
package adc_rdport_pkg;

    localparam int WORD_LONG  = 24;
    localparam int WORD_SHORT = 16;
    localparam int CNT_W      = $clog2(WORD_LONG + 1);

    typedef logic [WORD_LONG-1:0] word_t;

    typedef enum logic [1:0] {
        SRC_OUT  = 2'd0,
        SRC_CTRL = 2'd1,
        SRC_CAL  = 2'd2
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [CNT_W-1:0] len;
        word_t            data;
    } xfer_t;

    // Frame length: short only for a conversion word in 16-bit mode.
    function automatic logic [CNT_W-1:0] frame_len(src_e s, logic long_mode);
        return (s == SRC_OUT && !long_mode) ? CNT_W'(WORD_SHORT) : CNT_W'(WORD_LONG);
    endfunction

    // Left-align a conversion word so the first bit sent is the MSB of the frame.
    function automatic word_t align_word(word_t w, logic long_mode);
        return long_mode ? w : {w[WORD_SHORT-1:0], {(WORD_LONG-WORD_SHORT){1'b0}}};
    endfunction

endpackage

// File: rtl/sclk_edge.sv
module sclk_edge #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    output logic fall_o
);
    logic [STAGES-1:0] smp;

    always_ff @(posedge clk) begin
        if (rst) smp <= '0;
        else     smp <= {smp[STAGES-2:0], sclk_in};
    end

    // Oldest stage high, next stage low: a settled high-to-low transition.
    assign fall_o = smp[STAGES-1] & ~smp[STAGES-2];
endmodule

// File: rtl/rd_shifter.sv
module rd_shifter
    import adc_rdport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  xfer_t load,
    input  logic  rd_n,
    input  logic  fall,
    output logic  busy_o,
    output src_e  src_o,
    output logic  done_o,
    output logic  sdata_o,
    output logic  oe_o
);
    word_t            shreg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    logic             step;

    assign step   = busy_o & ~rd_n & fall;
    assign done_o = step & (cnt == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            src_o  <= SRC_OUT;
            shreg  <= '0;
            cnt    <= '0;
            len    <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            src_o  <= load.src;
            shreg  <= load.data;
            cnt    <= '0;
            len    <= load.len;
        end else if (step) begin
            shreg <= {shreg[WORD_LONG-2:0], 1'b0};
            if (done_o) busy_o <= 1'b0;
            else        cnt    <= cnt + 1'b1;
        end
    end

    assign oe_o    = busy_o & ~rd_n;
    assign sdata_o = shreg[WORD_LONG-1] & oe_o;
endmodule

// File: rtl/ready_store.sv
module ready_store
    import adc_rdport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_valid,
    input  word_t word_data,
    input  logic  hold,
    input  logic  clear,
    output word_t word_o,
    output logic  drdy_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            drdy_n <= 1'b1;
        end else begin
            if (clear) drdy_n <= 1'b1;
            if (word_valid && !hold) begin
                word_o <= word_data;
                drdy_n <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_rdport.sv
module adc_rdport
    import adc_rdport_pkg::*;
#(
    parameter int N_CAL       = 2,
    parameter int SYNC_STAGES = 3,
    localparam int CIDX_W     = (N_CAL > 1) ? $clog2(N_CAL) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sclk_in,
    input  logic                      rd_n,
    input  logic                      addr_hi,
    input  logic                      cal_en,
    input  logic [CIDX_W-1:0]         cal_idx,
    input  logic                      len24,
    input  logic                      word_valid,
    input  logic [WORD_LONG-1:0]      word_data,
    input  logic [WORD_LONG-1:0]      ctrl_word,
    input  logic [N_CAL*WORD_LONG-1:0] cal_words,
    output logic                      sdata_out,
    output logic                      sdata_oe,
    output logic                      drdy_n
);
    word_t cal_arr [N_CAL];
    word_t cal_pick;
    word_t out_word;
    xfer_t req;
    logic  sclk_fall, busy, done, start, hold, rd_q;
    src_e  src_q;

    for (genvar g = 0; g < N_CAL; g++) begin : g_cal
        assign cal_arr[g] = cal_words[g*WORD_LONG +: WORD_LONG];
    end

    always_comb begin
        cal_pick = '0;
        for (int i = 0; i < N_CAL; i++)
            if (cal_idx == CIDX_W'(i)) cal_pick = cal_arr[i];
    end

    always_comb begin
        if (!addr_hi)    req.src = SRC_CTRL;
        else if (cal_en) req.src = SRC_CAL;
        else             req.src = SRC_OUT;
        req.len = frame_len(req.src, len24);
        unique case (req.src)
            SRC_CTRL: req.data = ctrl_word;
            SRC_CAL:  req.data = cal_pick;
            default:  req.data = align_word(out_word, len24);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b1;
        else     rd_q <= rd_n;
    end

    // Start on a strobe falling edge; conversion reads need the flag low.
    assign start = rd_q & ~rd_n & ~busy & ((req.src != SRC_OUT) | ~drdy_n);
    assign hold  = (busy & (src_q == SRC_OUT)) | (start & (req.src == SRC_OUT));

    sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .sclk_in (sclk_in),
        .fall_o  (sclk_fall)
    );

    rd_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (req),
        .rd_n    (rd_n),
        .fall    (sclk_fall),
        .busy_o  (busy),
        .src_o   (src_q),
        .done_o  (done),
        .sdata_o (sdata_out),
        .oe_o    (sdata_oe)
    );

    ready_store u_store (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_data  (word_data),
        .hold       (hold),
        .clear      (done & (src_q == SRC_OUT)),
        .word_o     (out_word),
        .drdy_n     (drdy_n)
    );
endmodule

// File: rtl/adc_rdport_chk.sv
module adc_rdport_chk
    import adc_rdport_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic fall,
    input logic busy,
    input src_e src_q,
    input logic word_valid,
    input logic drdy_n,
    input logic sdata_oe
);
    // R5: the flag only rises on a synchronised SCLK falling edge.
    p_rise_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $past(fall));

    // R5: the data output is off once the flag has risen.
    p_oe_off_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> !sdata_oe);

    // R6: the flag stays low for the whole of a conversion-word read.
    p_flag_low_in_read_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && src_q == SRC_OUT) |-> !drdy_n);

    // R9: only a conversion-word read can raise the flag.
    p_ctrl_no_raise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $past(busy && src_q == SRC_OUT));

    // R4: an accepted word leaves the flag low.
    p_word_lowers_r4: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !busy) |=> !drdy_n);
endmodule

bind adc_rdport adc_rdport_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fall       (sclk_fall),
    .busy       (busy),
    .src_q      (src_q),
    .word_valid (word_valid),
    .drdy_n     (drdy_n),
    .sdata_oe   (sdata_oe)
);

// File: tb/adc_rdport_test.sv
module adc_rdport_test;
    import adc_rdport_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_in = 1'b1, rd_n = 1'b1, addr_hi = 1'b0, cal_en = 1'b0, len24 = 1'b1;
    logic [0:0] cal_idx = '0;
    logic word_valid = 1'b0;
    logic [23:0] word_data = '0;
    logic [23:0] ctrl_word = 24'hA5C3E1;
    logic [47:0] cal_words = {24'hFEDCBA, 24'h123456};
    logic sdata_out, sdata_oe, drdy_n;

    always #10 clk = ~clk;

    adc_rdport uut (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .rd_n(rd_n),
        .addr_hi(addr_hi), .cal_en(cal_en), .cal_idx(cal_idx), .len24(len24),
        .word_valid(word_valid), .word_data(word_data),
        .ctrl_word(ctrl_word), .cal_words(cal_words),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .drdy_n(drdy_n)
    );

    int n_chk = 0, n_fail = 0;
    logic [23:0] acc;
    int nb;

    typedef struct packed {
        logic a; logic c; logic i; logic w; logic p;
        logic [23:0] nw; logic [4:0] len; logic [23:0] exp; logic ehi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'h0,      5'd24, 24'hA5C3E1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 24'h0,      5'd24, 24'h123456, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h0,      5'd24, 24'hFEDCBA, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 24'h9B7D3F, 5'd24, 24'h9B7D3F, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 24'h77BEEF, 5'd16, 24'h00BEEF, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'h0,      5'd24, 24'hA5C3E1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [23:0] w);
        word_data = w; word_valid = 1'b1;
        waitn(1);
        word_valid = 1'b0;
        waitn(1);
    endtask

    task automatic cap();
        if (sdata_oe) begin acc = {acc[22:0], sdata_out}; nb++; end
    endtask

    task automatic strobe_low(input bit take);
        rd_n = 1'b0;
        waitn(2);
        if (take) cap();
    endtask

    task automatic pulses(input int k);
        repeat (k) begin
            sclk_in = 1'b0; waitn(4); cap();
            sclk_in = 1'b1; waitn(4);
        end
    endtask

    task automatic full_read(input int n);
        acc = '0; nb = 0;
        strobe_low(1);
        pulses(n);
        rd_n = 1'b1;
        waitn(2);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        waitn(3);
        rst = 1'b0;
        waitn(1);
        chk("R11 drdy_n", 32'(drdy_n), 32'd1);
        chk("R11 sdata_oe", 32'(sdata_oe), 32'd0);
        chk("R11 sdata_out", 32'(sdata_out), 32'd0);

        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            string tag = !v.a ? "R1" : (v.c ? "R2" : "R3");
            addr_hi = v.a; cal_en = v.c; cal_idx = v.i; len24 = v.w;
            if (v.p) push(v.nw);
            full_read(int'(v.len));
            chk({tag, " value"}, 32'(acc), 32'(v.exp));
            chk({tag, " bits"}, 32'(nb), 32'(v.len));
            chk(v.p ? "R5 flag after read" : "R9 flag after read", 32'(drdy_n), 32'(v.ehi));
        end

        // R7: conversion read with the flag high does nothing
        len24 = 1'b1; addr_hi = 1'b1; cal_en = 1'b0;
        acc = '0; nb = 0;
        strobe_low(1);
        pulses(3);
        chk("R7 oe", 32'(sdata_oe), 32'd0);
        chk("R7 bits", 32'(nb), 32'd0);
        rd_n = 1'b1; waitn(2);

        // R4: unread words are overwritten, read returns the latest
        push(24'hAAAAAA);
        chk("R4 flag low", 32'(drdy_n), 32'd0);
        push(24'h5A5A5A);
        full_read(24);
        chk("R4 latest word", 32'(acc), 32'h5A5A5A);
        chk("R4 flag high", 32'(drdy_n), 32'd1);

        // R6: word arriving mid-read is dropped
        push(24'h13579B);
        acc = '0; nb = 0;
        strobe_low(1);
        pulses(5);
        push(24'h2468AC);
        chk("R6 flag mid", 32'(drdy_n), 32'd0);
        pulses(19);
        rd_n = 1'b1; waitn(2);
        chk("R6 value", 32'(acc), 32'h13579B);
        chk("R6 flag after", 32'(drdy_n), 32'd1);

        // R8 and R5: pause, resume, final edges
        push(24'hC0FFEE);
        acc = '0; nb = 0;
        strobe_low(1);
        pulses(10);
        rd_n = 1'b1; waitn(2);
        chk("R8 oe released", 32'(sdata_oe), 32'd0);
        chk("R8 flag held", 32'(drdy_n), 32'd0);
        pulses(3);
        strobe_low(0);
        pulses(13);
        chk("R5 oe at LSB", 32'(sdata_oe), 32'd1);
        chk("R5 flag at LSB", 32'(drdy_n), 32'd0);
        chk("R5 LSB", 32'(sdata_out), 32'd0);
        pulses(1);
        chk("R5 flag rises", 32'(drdy_n), 32'd1);
        chk("R5 oe off", 32'(sdata_oe), 32'd0);
        chk("R8 value", 32'(acc), 32'hC0FFEE);
        chk("R8 bits", 32'(nb), 32'd24);
        rd_n = 1'b1; waitn(2);

        // R10: strobe held low after a control frame starts nothing
        addr_hi = 1'b0;
        acc = '0; nb = 0;
        strobe_low(1);
        pulses(24);
        waitn(6);
        chk("R10 no restart", 32'(sdata_oe), 32'd0);
        chk("R1 held strobe value", 32'(acc), 32'hA5C3E1);
        rd_n = 1'b1; waitn(2);

        // R10 latency, then R9: word during a control read is accepted
        acc = '0; nb = 0;
        strobe_low(1);
        sclk_in = 1'b0;
        waitn(1);
        chk("R10 not yet shifted", 32'(sdata_out), 32'd1);
        waitn(3);
        chk("R10 shifted", 32'(sdata_out), 32'd0);
        cap();
        sclk_in = 1'b1; waitn(4);
        pulses(5);
        push(24'h0F0F0F);
        chk("R9 flag low mid ctrl", 32'(drdy_n), 32'd0);
        pulses(18);
        rd_n = 1'b1; waitn(2);
        chk("R9 ctrl value", 32'(acc), 32'hA5C3E1);
        chk("R9 flag kept", 32'(drdy_n), 32'd0);

        // R11: reset again
        rst = 1'b1; waitn(2); rst = 1'b0; waitn(1);
        chk("R11 flag after reset", 32'(drdy_n), 32'd1);

        finish_run();
    end
endmodule